// File: doc/BRIEF.md
# 16-bit Register-Pair Arithmetic Unit

This execution unit carries out the 16-bit arithmetic group of a small CPU that keeps its general registers in pairs. Each cycle in which `valid_i` is high, it decodes one opcode and reads the optional signed immediate byte, the four pair values (BC, DE, HL, SP) and the flag byte. It then computes the new pair value and the new flags.

The group has four kinds of operation:
- adding a pair into HL;
- adding a sign-extended byte to SP;
- incrementing a pair;
- decrementing a pair.

The outcome is registered. One cycle later the unit presents four pair outputs, four per-pair write enables, the new flag byte and a cycle count. Each pair output carries either the new value or the old value passed through. The surrounding core writes back the pairs whose enables are set.

The unit has no register file of its own. It also does no fetch and no memory access. Opcodes outside the group raise `illegal_o`, and in that case no pair is written.

Top module: `pair_arith_unit`

## Requirements
- R1: Opcodes 0x09, 0x19, 0x29 and 0x39 add BC, DE, HL or SP into HL. The source pair is chosen by opcode bits 5:4 (0=BC, 1=DE, 2=HL, 3=SP). HL receives the sum modulo 2^16, and only `hl_we_o` is raised.
- R2: For the add-into-HL opcodes:
  - N is cleared.
  - H is set when bits 11:0 of the two operands carry out of bit 11.
  - C is set when the 17-bit sum exceeds 0xFFFF.
  - Z keeps its incoming value.
- R3: Opcode 0xE8 writes SP plus the sign-extended immediate byte, modulo 2^16, into SP. Z and N are cleared, and only `sp_we_o` is raised.
- R4: For 0xE8, H is the carry out of the unsigned sum of SP bits 3:0 and the immediate bits 3:0. C is the carry out of the unsigned sum of SP bits 7:0 and the raw immediate byte. This holds for both signs of the immediate.
- R5: Opcodes 0x03, 0x13, 0x23 and 0x33 increment the pair selected by bits 5:4. The value 0xFFFF wraps to 0x0000.
- R6: Opcodes 0x0B, 0x1B, 0x2B and 0x3B decrement the pair selected by bits 5:4. The value 0x0000 wraps to 0xFFFF.
- R7: Increment and decrement leave Z, N, H and C equal to their incoming values.
- R8: `cycles_o` reports 8 for add-into-HL, increment and decrement, 16 for 0xE8, and 0 for an unrecognised opcode.
- R9: Any other opcode raises `illegal_o`. It raises no write enable and leaves Z, N, H and C at their incoming values.
- R10: The flag byte holds Z in bit 7, N in bit 6, H in bit 5 and C in bit 4. Bits 3:0 of `flags_o` are always zero, whatever `flags_i[3:0]` holds.
- R11: Results appear on the outputs in the cycle after `valid_i` is sampled high, with `valid_o` high. In a cycle after `valid_i` was low, `valid_o`, `illegal_o` and all write enables are low.
- R12: While `rst_ni` is low, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation present this cycle |
| opcode_i | input | 8 | Opcode |
| imm_i | input | 8 | Immediate byte (two's complement for 0xE8) |
| bc_i | input | 16 | Current BC |
| de_i | input | 16 | Current DE |
| hl_i | input | 16 | Current HL |
| sp_i | input | 16 | Current SP |
| flags_i | input | 8 | Current flag byte |
| valid_o | output | 1 | Registered result valid |
| illegal_o | output | 1 | Opcode not in this group |
| bc_o | output | 16 | BC after the operation |
| de_o | output | 16 | DE after the operation |
| hl_o | output | 16 | HL after the operation |
| sp_o | output | 16 | SP after the operation |
| bc_we_o | output | 1 | Write BC |
| de_we_o | output | 1 | Write DE |
| hl_we_o | output | 1 | Write HL |
| sp_we_o | output | 1 | Write SP |
| flags_o | output | 8 | Flag byte after the operation |
| cycles_o | output | 5 | Reported clock cycles |

## Verification
The bench builds the unit with its default parameters. These are a 16-bit pair width, a 5-bit cycle field, and cycle counts of 8 and 16.

At that width, the bit-11 half-carry and the bit-15 carry of the add-into-HL path can be reached directly. So can the 0xFFFF and 0x0000 wrap points of increment and decrement. For the signed SP add, the bench drives immediates of 0x01, 0x7F, 0x80 and 0xFF, so the nibble and byte carries are exercised with both signs of the operand.

// File: rtl/pair_arith_pkg.sv
package pair_arith_pkg;

  typedef enum logic [2:0] {
    KIND_ADD_HL,
    KIND_ADD_SP,
    KIND_INC,
    KIND_DEC,
    KIND_ILLEGAL
  } op_kind_e;

  // encoding matches opcode bits 5:4
  typedef enum logic [1:0] {
    PAIR_BC = 2'd0,
    PAIR_DE = 2'd1,
    PAIR_HL = 2'd2,
    PAIR_SP = 2'd3
  } pair_e;

  localparam int NUM_PAIRS = 4;
  localparam int FLAG_Z    = 7;
  localparam int FLAG_N    = 6;
  localparam int FLAG_H    = 5;
  localparam int FLAG_C    = 4;

endpackage

// File: rtl/pair_arith_decode.sv
module pair_arith_decode
  import pair_arith_pkg::*;
(
  input  logic [7:0] opcode_i,
  output op_kind_e   kind_o,
  output pair_e      src_o,
  output pair_e      dst_o
);

  always_comb begin
    kind_o = KIND_ILLEGAL;
    src_o  = pair_e'(opcode_i[5:4]);
    dst_o  = pair_e'(opcode_i[5:4]);
    casez (opcode_i)
      8'b00??_1001: begin
        kind_o = KIND_ADD_HL;
        dst_o  = PAIR_HL;
      end
      8'b00??_0011: kind_o = KIND_INC;
      8'b00??_1011: kind_o = KIND_DEC;
      8'hE8: begin
        kind_o = KIND_ADD_SP;
        src_o  = PAIR_SP;
        dst_o  = PAIR_SP;
      end
      default: kind_o = KIND_ILLEGAL;
    endcase
  end

endmodule

// File: rtl/pair_arith_datapath.sv
module pair_arith_datapath
  import pair_arith_pkg::*;
#(
  parameter int WORD_W    = 16,
  parameter int CYC_W     = 5,
  parameter int SHORT_CYC = 8,
  parameter int LONG_CYC  = 16
) (
  input  op_kind_e                             kind_i,
  input  pair_e                                src_i,
  input  pair_e                                dst_i,
  input  logic [7:0]                           imm_i,
  input  logic [NUM_PAIRS-1:0][WORD_W-1:0]     pairs_i,
  input  logic [7:0]                           flags_i,
  output logic [NUM_PAIRS-1:0][WORD_W-1:0]     pairs_o,
  output logic [NUM_PAIRS-1:0]                 we_o,
  output logic [7:0]                           flags_o,
  output logic [CYC_W-1:0]                     cycles_o,
  output logic                                 illegal_o
);

  localparam int HB = WORD_W - 5;  // half-carry boundary for the wide add

  logic [WORD_W-1:0] src_val, dst_val, hl_val, sp_val, sext_imm, result;
  logic [WORD_W:0]   wide_sum;
  logic [HB+1:0]     half_sum;
  logic [8:0]        byte_sum;
  logic [4:0]        nib_sum;
  logic              writes;

  assign src_val  = pairs_i[src_i];
  assign dst_val  = pairs_i[dst_i];
  assign hl_val   = pairs_i[PAIR_HL];
  assign sp_val   = pairs_i[PAIR_SP];
  assign sext_imm = {{(WORD_W-8){imm_i[7]}}, imm_i};

  assign wide_sum = {1'b0, hl_val} + {1'b0, src_val};
  assign half_sum = {1'b0, hl_val[HB:0]} + {1'b0, src_val[HB:0]};
  assign byte_sum = {1'b0, sp_val[7:0]} + {1'b0, imm_i};
  assign nib_sum  = {1'b0, sp_val[3:0]} + {1'b0, imm_i[3:0]};

  always_comb begin
    result    = dst_val;
    flags_o   = {flags_i[7:4], 4'b0000};
    cycles_o  = CYC_W'(SHORT_CYC);
    writes    = 1'b1;
    illegal_o = 1'b0;
    unique case (kind_i)
      KIND_ADD_HL: begin
        result          = wide_sum[WORD_W-1:0];
        flags_o[FLAG_N] = 1'b0;
        flags_o[FLAG_H] = half_sum[HB+1];
        flags_o[FLAG_C] = wide_sum[WORD_W];
      end
      KIND_ADD_SP: begin
        result   = sp_val + sext_imm;
        flags_o  = 8'h00;
        flags_o[FLAG_H] = nib_sum[4];
        flags_o[FLAG_C] = byte_sum[8];
        cycles_o = CYC_W'(LONG_CYC);
      end
      KIND_INC: result = dst_val + WORD_W'(1);
      KIND_DEC: result = dst_val - WORD_W'(1);
      default: begin
        writes    = 1'b0;
        illegal_o = 1'b1;
        cycles_o  = '0;
      end
    endcase
  end

  for (genvar g = 0; g < NUM_PAIRS; g++) begin : g_pair
    assign we_o[g]    = writes && (dst_i == pair_e'(g));
    assign pairs_o[g] = we_o[g] ? result : pairs_i[g];
  end

endmodule

// File: rtl/pair_arith_wb.sv
module pair_arith_wb
  import pair_arith_pkg::*;
#(
  parameter int WORD_W    = 16,
  parameter int CYC_W     = 5,
  parameter int SHORT_CYC = 8,
  parameter int LONG_CYC  = 16
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             valid_i,
  input  op_kind_e                         kind_i,
  input  logic [7:0]                       flags_in_i,
  input  logic [NUM_PAIRS-1:0][WORD_W-1:0] pairs_i,
  input  logic [NUM_PAIRS-1:0]             we_i,
  input  logic [7:0]                       flags_i,
  input  logic [CYC_W-1:0]                 cycles_i,
  input  logic                             illegal_i,
  output logic                             valid_o,
  output logic [NUM_PAIRS-1:0][WORD_W-1:0] pairs_o,
  output logic [NUM_PAIRS-1:0]             we_o,
  output logic [7:0]                       flags_o,
  output logic [CYC_W-1:0]                 cycles_o,
  output logic                             illegal_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o   <= 1'b0;
      pairs_o   <= '0;
      we_o      <= '0;
      flags_o   <= '0;
      cycles_o  <= '0;
      illegal_o <= 1'b0;
    end else begin
      valid_o   <= valid_i;
      we_o      <= valid_i ? we_i : '0;
      illegal_o <= valid_i && illegal_i;
      if (valid_i) begin
        pairs_o  <= pairs_i;
        flags_o  <= flags_i;
        cycles_o <= cycles_i;
      end
    end
  end

  assert_single_write_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(we_o));

  assert_idle_quiet_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> (!valid_o && we_o == '0 && !illegal_o));

  assert_illegal_no_write_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && kind_i == KIND_ILLEGAL) |=>
      (illegal_o && we_o == '0 && flags_o == {$past(flags_in_i[7:4]), 4'b0000}));

  assert_incdec_flags_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && (kind_i == KIND_INC || kind_i == KIND_DEC)) |=>
      (flags_o == {$past(flags_in_i[7:4]), 4'b0000}));

  assert_flag_low_zero_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flags_o[3:0] == 4'b0000);

  assert_cycle_count_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !illegal_o) |->
      (cycles_o == CYC_W'(SHORT_CYC) || cycles_o == CYC_W'(LONG_CYC)));

endmodule

// File: rtl/pair_arith_unit.sv
module pair_arith_unit
  import pair_arith_pkg::*;
#(
  parameter int WORD_W    = 16,
  parameter int CYC_W     = 5,
  parameter int SHORT_CYC = 8,
  parameter int LONG_CYC  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [7:0]        opcode_i,
  input  logic [7:0]        imm_i,
  input  logic [WORD_W-1:0] bc_i,
  input  logic [WORD_W-1:0] de_i,
  input  logic [WORD_W-1:0] hl_i,
  input  logic [WORD_W-1:0] sp_i,
  input  logic [7:0]        flags_i,
  output logic              valid_o,
  output logic              illegal_o,
  output logic [WORD_W-1:0] bc_o,
  output logic [WORD_W-1:0] de_o,
  output logic [WORD_W-1:0] hl_o,
  output logic [WORD_W-1:0] sp_o,
  output logic              bc_we_o,
  output logic              de_we_o,
  output logic              hl_we_o,
  output logic              sp_we_o,
  output logic [7:0]        flags_o,
  output logic [CYC_W-1:0]  cycles_o
);

  op_kind_e                         kind;
  pair_e                            src, dst;
  logic [NUM_PAIRS-1:0][WORD_W-1:0] pairs_in, pairs_nxt, pairs_q;
  logic [NUM_PAIRS-1:0]             we_nxt, we_q;
  logic [7:0]                       flags_nxt;
  logic [CYC_W-1:0]                 cycles_nxt;
  logic                             illegal_nxt;

  assign pairs_in = {sp_i, hl_i, de_i, bc_i};

  pair_arith_decode u_decode (
    .opcode_i (opcode_i),
    .kind_o   (kind),
    .src_o    (src),
    .dst_o    (dst)
  );

  pair_arith_datapath #(
    .WORD_W(WORD_W), .CYC_W(CYC_W), .SHORT_CYC(SHORT_CYC), .LONG_CYC(LONG_CYC)
  ) u_datapath (
    .kind_i    (kind),
    .src_i     (src),
    .dst_i     (dst),
    .imm_i     (imm_i),
    .pairs_i   (pairs_in),
    .flags_i   (flags_i),
    .pairs_o   (pairs_nxt),
    .we_o      (we_nxt),
    .flags_o   (flags_nxt),
    .cycles_o  (cycles_nxt),
    .illegal_o (illegal_nxt)
  );

  pair_arith_wb #(
    .WORD_W(WORD_W), .CYC_W(CYC_W), .SHORT_CYC(SHORT_CYC), .LONG_CYC(LONG_CYC)
  ) u_wb (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .valid_i    (valid_i),
    .kind_i     (kind),
    .flags_in_i (flags_i),
    .pairs_i    (pairs_nxt),
    .we_i       (we_nxt),
    .flags_i    (flags_nxt),
    .cycles_i   (cycles_nxt),
    .illegal_i  (illegal_nxt),
    .valid_o    (valid_o),
    .pairs_o    (pairs_q),
    .we_o       (we_q),
    .flags_o    (flags_o),
    .cycles_o   (cycles_o),
    .illegal_o  (illegal_o)
  );

  assign bc_o    = pairs_q[PAIR_BC];
  assign de_o    = pairs_q[PAIR_DE];
  assign hl_o    = pairs_q[PAIR_HL];
  assign sp_o    = pairs_q[PAIR_SP];
  assign bc_we_o = we_q[PAIR_BC];
  assign de_we_o = we_q[PAIR_DE];
  assign hl_we_o = we_q[PAIR_HL];
  assign sp_we_o = we_q[PAIR_SP];

endmodule

// File: tb/pair_arith_unit_tb_top.sv
`timescale 1ns/1ps
module pair_arith_unit_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic [7:0]  opcode = '0, imm = '0, flags = '0;
  logic [15:0] bc = '0, de = '0, hl = '0, sp = '0;
  logic        valid_o, illegal_o, bc_we, de_we, hl_we, sp_we;
  logic [15:0] bc_o, de_o, hl_o, sp_o;
  logic [7:0]  flags_o;
  logic [4:0]  cycles_o;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;  // 125 MHz

  pair_arith_unit dut_i (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .opcode_i(opcode), .imm_i(imm),
    .bc_i(bc), .de_i(de), .hl_i(hl), .sp_i(sp), .flags_i(flags),
    .valid_o(valid_o), .illegal_o(illegal_o),
    .bc_o(bc_o), .de_o(de_o), .hl_o(hl_o), .sp_o(sp_o),
    .bc_we_o(bc_we), .de_we_o(de_we), .hl_we_o(hl_we), .sp_we_o(sp_we),
    .flags_o(flags_o), .cycles_o(cycles_o)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // drive one op at negedge, sample one cycle later, after the edge
  task automatic issue(input logic [7:0] op, input logic [7:0] im,
                       input logic [15:0] b, d, h, s, input logic [7:0] f);
    @(negedge clk);
    valid = 1'b1; opcode = op; imm = im; bc = b; de = d; hl = h; sp = s; flags = f;
    @(posedge clk); #1;
  endtask

  // idx: 0=BC 1=DE 2=HL 3=SP
  task automatic expect_wr(input string req, input int idx, input logic [15:0] val,
                           input logic [7:0] fl, input logic [4:0] cyc);
    logic [15:0] outs [4];
    logic [15:0] ins  [4];
    outs = '{bc_o, de_o, hl_o, sp_o};
    ins  = '{bc, de, hl, sp};
    chk(req, "valid_o", valid_o, 1);
    chk(req, "illegal_o", illegal_o, 0);
    chk(req, "we {sp,hl,de,bc}", {sp_we, hl_we, de_we, bc_we}, 32'(1 << idx));
    for (int k = 0; k < 4; k++)
      chk(req, $sformatf("pair%0d", k), outs[k], (k == idx) ? val : ins[k]);
    chk(req, "flags", flags_o, fl);
    chk(req, "cycles", cycles_o, cyc);
  endtask

  task automatic t_reset;
    #1;
    chk("R12", "valid_o", valid_o, 0);
    chk("R12", "we", {sp_we, hl_we, de_we, bc_we}, 0);
    chk("R12", "illegal", illegal_o, 0);
    chk("R12", "flags", flags_o, 0);
    chk("R12", "hl", hl_o, 0);
    chk("R12", "cycles", cycles_o, 0);
  endtask

  task automatic t_add_hl;
    issue(8'h09, 8'h00, 16'h0001, 16'h5555, 16'h0FFF, 16'h7777, 8'hC0);
    expect_wr("R1 R2 half", 2, 16'h1000, 8'hA0, 5'd8);
    issue(8'h29, 8'h00, 16'h1111, 16'h2222, 16'h8000, 16'h3333, 8'h00);
    expect_wr("R1 R2 carry", 2, 16'h0000, 8'h10, 5'd8);
    issue(8'h19, 8'h00, 16'h0000, 16'h8001, 16'h8FFF, 16'h0000, 8'h4F);
    expect_wr("R2 R10 both", 2, 16'h1000, 8'h30, 5'd8);
    issue(8'h39, 8'h00, 16'h0000, 16'h0000, 16'h1234, 16'h1111, 8'h80);
    expect_wr("R1 R2 none", 2, 16'h2345, 8'h80, 5'd8);
  endtask

  task automatic t_add_sp;
    issue(8'hE8, 8'h01, 16'h1, 16'h2, 16'h3, 16'h00FF, 8'hF0);
    expect_wr("R3 R4 pos carry", 3, 16'h0100, 8'h30, 5'd16);
    issue(8'hE8, 8'hFF, 16'h1, 16'h2, 16'h3, 16'h0005, 8'hF0);
    expect_wr("R3 R4 minus1", 3, 16'h0004, 8'h30, 5'd16);
    issue(8'hE8, 8'h80, 16'h1, 16'h2, 16'h3, 16'h0000, 8'hF0);
    expect_wr("R3 R4 minus128", 3, 16'hFF80, 8'h00, 5'd16);
    issue(8'hE8, 8'h7F, 16'h1, 16'h2, 16'h3, 16'h1234, 8'h80);
    expect_wr("R3 R4 plus127", 3, 16'h12B3, 8'h20, 5'd16);
  endtask

  task automatic t_inc;
    issue(8'h03, 8'h00, 16'hFFFF, 16'h0, 16'h0, 16'h0, 8'hB0);
    expect_wr("R5 R7 wrap", 0, 16'h0000, 8'hB0, 5'd8);
    issue(8'h13, 8'h00, 16'h0, 16'h1234, 16'h0, 16'h0, 8'h4A);
    expect_wr("R5 R7 R10 de", 1, 16'h1235, 8'h40, 5'd8);
    issue(8'h23, 8'h00, 16'h0, 16'h0, 16'h00FF, 16'h0, 8'h00);
    expect_wr("R5 hl", 2, 16'h0100, 8'h00, 5'd8);
    issue(8'h33, 8'h00, 16'h0, 16'h0, 16'h0, 16'hFFFE, 8'hF0);
    expect_wr("R5 sp", 3, 16'hFFFF, 8'hF0, 5'd8);
  endtask

  task automatic t_dec;
    issue(8'h2B, 8'h00, 16'h9, 16'h9, 16'h0000, 16'h9, 8'h50);
    expect_wr("R6 R7 wrap", 2, 16'hFFFF, 8'h50, 5'd8);
    issue(8'h0B, 8'h00, 16'h0100, 16'h0, 16'h0, 16'h0, 8'hE0);
    expect_wr("R6 bc", 0, 16'h00FF, 8'hE0, 5'd8);
    issue(8'h1B, 8'h00, 16'h0, 16'h0001, 16'h0, 16'h0, 8'h10);
    expect_wr("R6 de", 1, 16'h0000, 8'h10, 5'd8);
    issue(8'h3B, 8'h00, 16'h0, 16'h0, 16'h0, 16'h8000, 8'h00);
    expect_wr("R6 sp", 3, 16'h7FFF, 8'h00, 5'd8);
  endtask

  task automatic t_illegal;
    logic [7:0] ops [4] = '{8'h00, 8'hFF, 8'h49, 8'h0A};
    for (int k = 0; k < 4; k++) begin
      issue(ops[k], 8'h12, 16'hAAAA, 16'hBBBB, 16'hCCCC, 16'hDDDD, 8'hD5);
      chk("R9", "valid_o", valid_o, 1);
      chk("R9", "illegal_o", illegal_o, 1);
      chk("R9", "we", {sp_we, hl_we, de_we, bc_we}, 0);
      chk("R9 R10", "flags", flags_o, 8'hD0);
      chk("R8", "cycles", cycles_o, 0);
    end
  endtask

  task automatic t_idle;
    issue(8'h03, 8'h00, 16'h1, 16'h0, 16'h0, 16'h0, 8'h00);
    @(negedge clk); valid = 1'b0; opcode = 8'h09;
    @(posedge clk); #1;
    chk("R11", "valid_o", valid_o, 0);
    chk("R11", "we", {sp_we, hl_we, de_we, bc_we}, 0);
    chk("R11", "illegal", illegal_o, 0);
    @(negedge clk); opcode = 8'h00;
    @(posedge clk); #1;
    chk("R11", "illegal idle", illegal_o, 0);
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    #20 rst_n = 1'b1;
    t_add_hl();
    t_add_sp();
    t_inc();
    t_dec();
    t_illegal();
    t_idle();
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

endmodule